// File: doc/BRIEF.md
# Command completion counter with level interrupt

This block keeps the completion bookkeeping for one DMA channel. A hardware counter advances by one on every completion pulse from the descriptor loader. Software keeps its own count of the completions it has handled, and the block raises an interrupt whenever the two counts disagree. Both counts are 6 bits wide and sit in one status register, so a single read gives software the number of outstanding completions as (done − handled) mod 64.

Software acknowledges by writing the done value it has just read into the handled field. In the same write it clears an interrupt-active flag. The done field is read-only, so a completion that arrives between that read and the write survives. Software can then read again and repeat until the done value stops moving. A small configuration register holds three controls: an enable for list events, an interrupt enable, and a choice between a level output and a one-cycle pulse output.

Top module: `cmdcnt_top`

## Requirements
- R1: After reset the done count, the handled count, the active flag and all three configuration bits are 0, and `irq` is low.
- R2: Each cycle with `evtPulse` high adds one to the done count (status bits 5:0), modulo 64, so 63 is followed by 0. The done count changes on no other condition.
- R3: A status write (`wrEn`=1, `wrSel`=1) loads `wrData[21:16]` into the handled count (status bits 21:16) and leaves the done count unchanged. All other written bits are ignored.
- R4: The active flag (status bit 8) is set by an event while list events are enabled. A status write with bit 8 = 0 clears it, and a status write with bit 8 = 1 leaves it unchanged.
- R5: If an event and a status write fall in the same cycle, the done count still increments and the active flag ends set (when list events are enabled). The handled count takes the written value.
- R6: In level mode (config bit 28 = 1), with config bits 29 and 31 set, `irq` is high exactly while the active flag is set or the done count differs from the handled count.
- R7: The outstanding count is (done − handled) mod 64. A handled count that is numerically larger than a done count which has wrapped still counts as outstanding, and only equality counts as none outstanding.
- R8: In pulse mode (config bit 28 = 0), with bits 29 and 31 set, `irq` is high for exactly the one cycle after each event that was accepted while list events were enabled.
- R9: `irq` stays low whenever config bit 29 (interrupt enable) or bit 31 (list event enable) is 0.
- R10: A configuration write (`wrEn`=1, `wrSel`=0) keeps `wrData` bits 31, 29 and 28. `rdData` shows the configuration register when `rdSel`=0 and the status register when `rdSel`=1, and every unused bit reads as 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| evtPulse | input | 1 | One completion per high cycle, from the descriptor loader |
| wrEn | input | 1 | Register write strobe |
| wrSel | input | 1 | Write target: 0 = configuration, 1 = status |
| wrData | input | 32 | Write data |
| rdSel | input | 1 | Read target: 0 = configuration, 1 = status |
| rdData | output | 32 | Combinational read data |
| irq | output | 1 | Interrupt output, level or pulse |

## Verification
The bench targets these corner cases:

- **Wrap past 63.** A counter that saturates, or that compares counts without modular arithmetic, either drops the interrupt early or keeps it high after a full acknowledge.
- **Event in the acknowledge cycle.** A design that lets the write win loses that completion. Its `irq` falls even though one completion is still outstanding.
- **Clearing the active flag.** A write with bit 8 = 1 must not clear the flag, and a write with bit 8 = 0 must not lose a set that arrives in the same cycle.
- **Disabled interrupt paths.** With either enable off, `irq` must stay low.
- **Pulse mode.** The output must last exactly one cycle per accepted event, never two cycles and never zero.

// File: rtl/cmdcnt_pkg.sv
package cmdcnt_pkg;
  // Field positions that software decodes
  localparam int DONE_LSB   = 0;
  localparam int ACT_BIT    = 8;
  localparam int PROC_LSB   = 16;
  localparam int LEVEL_BIT  = 28;
  localparam int INTEN_BIT  = 29;
  localparam int LISTEN_BIT = 31;

  // Strobes from control to datapath
  typedef struct packed {
    logic cntInc;
    logic procLoad;
    logic actSet;
    logic actClr;
    logic cfgLoad;
    logic pulseSet;
  } strobe_t;
endpackage

// File: rtl/cmdcnt_ctrl.sv
module cmdcnt_ctrl
  import cmdcnt_pkg::*;
#(
  parameter int CNT_W  = 6,
  parameter int DATA_W = 32
) (
  input  logic              evtPulse,
  input  logic              wrEn,
  input  logic              wrSel,
  input  logic [DATA_W-1:0] wrData,
  input  logic              listEn,
  input  logic              intEn,
  input  logic              levelMode,
  input  logic [CNT_W-1:0]  doneCnt,
  input  logic [CNT_W-1:0]  procCnt,
  input  logic              activeQ,
  input  logic              pulseQ,
  output strobe_t           stb,
  output logic              irq
);
  logic [CNT_W-1:0] pendingCnt;
  logic             statusWr;

  assign statusWr = wrEn & wrSel;

  always_comb begin
    stb          = '0;
    stb.cntInc   = evtPulse;
    stb.actSet   = evtPulse & listEn;
    stb.pulseSet = evtPulse & listEn;
    stb.procLoad = statusWr;
    // a set in the same cycle wins over a clear
    stb.actClr   = statusWr & ~wrData[ACT_BIT] & ~(evtPulse & listEn);
    stb.cfgLoad  = wrEn & ~wrSel;
  end

  // modular distance between the two counts
  assign pendingCnt = doneCnt - procCnt;

  always_comb begin
    if (!(intEn && listEn)) irq = 1'b0;
    else if (levelMode)     irq = activeQ | (pendingCnt != '0);
    else                    irq = pulseQ;
  end
endmodule

// File: rtl/cmdcnt_dpath.sv
module cmdcnt_dpath
  import cmdcnt_pkg::*;
#(
  parameter int CNT_W  = 6,
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rstN,
  input  strobe_t           stb,
  input  logic [DATA_W-1:0] wrData,
  input  logic              rdSel,
  output logic [DATA_W-1:0] rdData,
  output logic [CNT_W-1:0]  doneCnt,
  output logic [CNT_W-1:0]  procCnt,
  output logic              activeQ,
  output logic              pulseQ,
  output logic              listEn,
  output logic              intEn,
  output logic              levelMode
);
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      doneCnt <= '0;
      procCnt <= '0;
      activeQ <= 1'b0;
      pulseQ  <= 1'b0;
    end else begin
      if (stb.cntInc)   doneCnt <= doneCnt + 1'b1;
      if (stb.procLoad) procCnt <= wrData[PROC_LSB +: CNT_W];
      if (stb.actSet)      activeQ <= 1'b1;
      else if (stb.actClr) activeQ <= 1'b0;
      pulseQ <= stb.pulseSet;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      listEn    <= 1'b0;
      intEn     <= 1'b0;
      levelMode <= 1'b0;
    end else if (stb.cfgLoad) begin
      listEn    <= wrData[LISTEN_BIT];
      intEn     <= wrData[INTEN_BIT];
      levelMode <= wrData[LEVEL_BIT];
    end
  end

  always_comb begin
    rdData = '0;
    if (rdSel) begin
      rdData[DONE_LSB +: CNT_W] = doneCnt;
      rdData[PROC_LSB +: CNT_W] = procCnt;
      rdData[ACT_BIT]           = activeQ;
    end else begin
      rdData[LISTEN_BIT] = listEn;
      rdData[INTEN_BIT]  = intEn;
      rdData[LEVEL_BIT]  = levelMode;
    end
  end
endmodule

// File: rtl/cmdcnt_top.sv
module cmdcnt_top
  import cmdcnt_pkg::*;
#(
  parameter int CNT_W  = 6,
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              evtPulse,
  input  logic              wrEn,
  input  logic              wrSel,
  input  logic [DATA_W-1:0] wrData,
  input  logic              rdSel,
  output logic [DATA_W-1:0] rdData,
  output logic              irq
);
  strobe_t          stb;
  logic [CNT_W-1:0] doneCnt;
  logic [CNT_W-1:0] procCnt;
  logic             activeQ;
  logic             pulseQ;
  logic             listEn;
  logic             intEn;
  logic             levelMode;

  cmdcnt_ctrl #(.CNT_W(CNT_W), .DATA_W(DATA_W)) i_ctrl (
    .evtPulse (evtPulse),
    .wrEn     (wrEn),
    .wrSel    (wrSel),
    .wrData   (wrData),
    .listEn   (listEn),
    .intEn    (intEn),
    .levelMode(levelMode),
    .doneCnt  (doneCnt),
    .procCnt  (procCnt),
    .activeQ  (activeQ),
    .pulseQ   (pulseQ),
    .stb      (stb),
    .irq      (irq)
  );

  cmdcnt_dpath #(.CNT_W(CNT_W), .DATA_W(DATA_W)) i_dpath (
    .clk      (clk),
    .rstN     (rstN),
    .stb      (stb),
    .wrData   (wrData),
    .rdSel    (rdSel),
    .rdData   (rdData),
    .doneCnt  (doneCnt),
    .procCnt  (procCnt),
    .activeQ  (activeQ),
    .pulseQ   (pulseQ),
    .listEn   (listEn),
    .intEn    (intEn),
    .levelMode(levelMode)
  );
endmodule

// File: rtl/cmdcnt_chk.sv
module cmdcnt_chk #(
  parameter int CNT_W  = 6,
  parameter int DATA_W = 32
) (
  input logic              clk,
  input logic              rstN,
  input logic              evtPulse,
  input logic              wrEn,
  input logic              wrSel,
  input logic [DATA_W-1:0] wrData,
  input logic              irq,
  input logic [CNT_W-1:0]  doneCnt,
  input logic [CNT_W-1:0]  procCnt,
  input logic              activeQ,
  input logic              listEn,
  input logic              intEn,
  input logic              levelMode
);
  assert_reset_clear_R1: assert property (@(posedge clk)
    !rstN |=> (doneCnt == '0 && procCnt == '0 && !activeQ && !irq));

  assert_done_inc_R2: assert property (@(posedge clk) disable iff (!rstN)
    evtPulse |=> doneCnt == CNT_W'($past(doneCnt) + 1'b1));

  assert_done_hold_R2: assert property (@(posedge clk) disable iff (!rstN)
    !evtPulse |=> $stable(doneCnt));

  assert_proc_load_R3: assert property (@(posedge clk) disable iff (!rstN)
    (wrEn && wrSel) |=> procCnt == $past(wrData[16 +: CNT_W]));

  assert_event_sets_flag_R5: assert property (@(posedge clk) disable iff (!rstN)
    (evtPulse && listEn) |=> activeQ);

  assert_level_irq_R6: assert property (@(posedge clk) disable iff (!rstN)
    (levelMode && intEn && listEn && (doneCnt != procCnt)) |-> irq);

  assert_pulse_irq_R8: assert property (@(posedge clk) disable iff (!rstN)
    (!levelMode && intEn && listEn) |-> (irq == $past(evtPulse && listEn)));

  assert_gate_off_R9: assert property (@(posedge clk) disable iff (!rstN)
    !(intEn && listEn) |-> !irq);
endmodule

bind cmdcnt_top cmdcnt_chk #(.CNT_W(CNT_W), .DATA_W(DATA_W)) i_chk (
  .clk      (clk),
  .rstN     (rstN),
  .evtPulse (evtPulse),
  .wrEn     (wrEn),
  .wrSel    (wrSel),
  .wrData   (wrData),
  .irq      (irq),
  .doneCnt  (doneCnt),
  .procCnt  (procCnt),
  .activeQ  (activeQ),
  .listEn   (listEn),
  .intEn    (intEn),
  .levelMode(levelMode)
);

// File: tb/test_cmdcnt_top.sv
`timescale 1ns/100ps
module test_cmdcnt_top;
  localparam int CNT_W  = 6;
  localparam int DATA_W = 32;

  logic              clk = 1'b0;
  logic              rstN = 1'b0;
  logic              evtPulse = 1'b0;
  logic              wrEn = 1'b0;
  logic              wrSel = 1'b0;
  logic [DATA_W-1:0] wrData = '0;
  logic              rdSel = 1'b0;
  logic [DATA_W-1:0] rdData;
  logic              irq;

  int checks = 0;
  int fails  = 0;
  bit finished = 0;

  // bench model of the register state
  logic [CNT_W-1:0] mDone, mProc;
  logic mAct, mPulse, mList, mInt, mLevel;

  always #2.5 clk = ~clk;

  cmdcnt_top #(.CNT_W(CNT_W), .DATA_W(DATA_W)) i_cmdcnt_top (
    .clk(clk), .rstN(rstN), .evtPulse(evtPulse), .wrEn(wrEn), .wrSel(wrSel),
    .wrData(wrData), .rdSel(rdSel), .rdData(rdData), .irq(irq)
  );

  function automatic logic [DATA_W-1:0] expStatus();
    logic [DATA_W-1:0] v = '0;
    v[5:0]   = mDone;
    v[21:16] = mProc;
    v[8]     = mAct;
    return v;
  endfunction

  function automatic logic [DATA_W-1:0] expCfg();
    logic [DATA_W-1:0] v = '0;
    v[31] = mList;
    v[29] = mInt;
    v[28] = mLevel;
    return v;
  endfunction

  function automatic logic expIrq();
    if (!(mInt && mList)) return 1'b0;
    if (mLevel) return mAct || (CNT_W'(mDone - mProc) != '0);
    return mPulse;
  endfunction

  task automatic check(string req, logic [DATA_W-1:0] act, logic [DATA_W-1:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h at %0t", req, act, exp, $time);
    end
  endtask

  // verify outputs against the model
  task automatic checkAll(string req);
    rdSel = 1'b1; #0.3;
    check(req, rdData, expStatus());
    rdSel = 1'b0; #0.3;
    check(req, rdData, expCfg());
    check(req, {31'b0, irq}, {31'b0, expIrq()});
  endtask

  // one clock with given stimulus; model follows the requirements
  task automatic step(logic evt, logic wen, logic wsel, logic [DATA_W-1:0] wd, string req);
    @(negedge clk);
    evtPulse = evt; wrEn = wen; wrSel = wsel; wrData = wd;
    @(posedge clk);
    begin
      logic nAct;
      nAct = mAct;
      if (wen && wsel && !wd[8]) nAct = 1'b0;       // R4
      if (evt && mList) nAct = 1'b1;                // R5 event wins
      mPulse = evt && mList;                        // R8
      if (evt) mDone = mDone + 1'b1;                // R2
      if (wen && wsel) mProc = wd[21:16];           // R3
      if (wen && !wsel) begin                       // R10
        mList = wd[31]; mInt = wd[29]; mLevel = wd[28];
      end
      mAct = nAct;
    end
    #0.4;
    checkAll(req);
  endtask

  function automatic logic [DATA_W-1:0] ack(logic [CNT_W-1:0] p, logic keepAct);
    logic [DATA_W-1:0] v = '0;
    v[21:16] = p;
    v[8] = keepAct;
    v[5:0] = ~p;   // ignored bits of the done field
    return v;
  endfunction

  initial begin
    #(200000 * 5);
    if (!finished) begin
      fails++;
      checks++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    int unsigned seedInit;
    seedInit = $urandom(32'd4242);
    mDone = '0; mProc = '0; mAct = 0; mPulse = 0; mList = 0; mInt = 0; mLevel = 0;
    #12;
    checkAll("R1");                    // during reset
    @(negedge clk); rstN = 1'b1;
    #0.4; checkAll("R1");

    // R10: config readback of kept bits only
    step(0, 1, 0, 32'hFFFF_FFFF, "R10");
    step(0, 1, 0, 32'h0000_0000, "R10");

    // R9: events with enables off raise nothing
    step(1, 0, 0, '0, "R9");
    step(0, 1, 0, 32'h1000_0000, "R9");  // level only, no enables
    step(1, 0, 0, '0, "R9");

    // clear out, enable list+int+level
    step(0, 1, 1, ack(mDone, 0), "R3");
    step(0, 1, 0, 32'hB000_0000, "R6");
    step(1, 0, 0, '0, "R6");
    step(0, 1, 1, ack(mProc, 1), "R4");    // bit 8 = 1 keeps the flag, done differs
    step(0, 1, 1, ack(mDone, 1), "R4");    // counts equal, flag still set
    step(0, 1, 1, ack(mDone, 0), "R4");    // flag cleared, irq low

    // R5: event during acknowledge
    step(1, 1, 1, ack(mDone, 0), "R5");
    step(0, 1, 1, ack(mDone, 0), "R5");

    // R2/R7: wrap past 63 with handled count ahead numerically
    step(0, 1, 1, ack(6'd62, 0), "R7");
    for (int i = 0; i < 64; i++) step(1, 0, 0, '0, "R2");
    step(0, 1, 1, ack(6'd61, 0), "R7");
    step(0, 1, 1, ack(mDone, 0), "R7");

    // R8: pulse mode
    step(0, 1, 0, 32'hA000_0000, "R8");
    step(1, 0, 0, '0, "R8");
    step(0, 0, 0, '0, "R8");
    step(1, 0, 0, '0, "R8");
    step(1, 0, 0, '0, "R8");

    // random mix
    for (int i = 0; i < 3000; i++) begin
      logic ev, we, ws;
      logic [DATA_W-1:0] wd;
      ev = ($urandom % 3) == 0;
      we = ($urandom % 4) == 0;
      ws = ($urandom % 5) != 0;
      wd = $urandom;
      if (ws && ($urandom % 2)) wd[21:16] = mDone;
      step(ev, we, ws, wd, "R6");
    end

    finished = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule